// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This block sits between a 32-bit integer core and a data memory that is one word wide. Each access comes in as an instruction word, together with the value of its base register and the value of its data register. The block works out the byte address as the base value plus the sign-extended 16-bit displacement. It then issues one registered request to the memory. The memory numbers its bytes big-endian, so address offset 0 is the most significant byte of a word.

For stores, the block copies the low byte, halfword or word of the data register onto the byte lanes that the address selects and sets the matching byte enables. For loads, it takes the addressed byte or halfword out of the word the memory returns. The opcode decides whether that value is sign-extended or zero-extended to 32 bits. The result is returned with a valid strobe and the destination register index.

An access whose size does not match its address alignment is not trapped. The block raises a one-cycle flag and sends nothing to the memory.

Top module: `be_lsu_align`

## Requirements
- R1: While and directly after synchronous reset, `mem_req`, `mem_we`, `mem_be`, `misalign` and `ld_valid` are all 0.
- R2: The byte address is `base_val` plus `instr[15:0]` sign-extended to 32 bits, wrapping modulo 2^32. For an accepted access, `mem_req` and `mem_addr` appear in the cycle after the one in which `req_valid` was sampled high.
- R3: A byte store (opcode field `instr[31:26]` = 12) drives `mem_be = 4'b1000 >> addr[1:0]`, so that enable bit 3 is address offset 0. It also places `data_val[7:0]` in all four byte lanes of `mem_wdata`.
- R4: A halfword store (opcode 3) drives `mem_be = 4'b1100` at offset 0 and `4'b0011` at offset 2. It places `data_val[15:0]` in both halves of `mem_wdata`.
- R5: A word store (opcode 22) drives `mem_be = 4'b1111` and `mem_wdata = data_val`. Stores raise `mem_we` and loads keep it low.
- R6: Byte loads take bits `[31-8*off -: 8]` of the returned word, where `off` is `addr[1:0]`. Opcode 4 sign-extends the byte and opcode 16 zero-extends it.
- R7: Halfword loads take bits 31:16 at offset 0 and bits 15:0 at offset 2. Opcode 7 sign-extends the halfword and opcode 11 zero-extends it.
- R8: A word load (opcode 10) returns the whole returned word unchanged.
- R9: The memory must present the addressed word on `mem_rdata` in the cycle after `mem_req`. In the cycle after that, `ld_valid` is high for exactly one cycle, with `ld_data` and with `ld_rd = instr[20:16]`. Stores never raise `ld_valid`.
- R10: A halfword access with `addr[0]` set, or a word access with `addr[1:0]` not zero, raises `misalign` for one cycle in the slot where `mem_req` would have appeared. That access leaves `mem_req` low, writes nothing and produces no `ld_valid`.
- R11: A cycle with `req_valid` low, or with an opcode outside the eight load/store codes, raises none of `mem_req`, `misalign` or `ld_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Instruction and operands below are valid this cycle |
| instr | input | 32 | Instruction word: opcode 31:26, base index 25:21, data/destination index 20:16, displacement 15:0 |
| base_val | input | 32 | Value of the base register |
| data_val | input | 32 | Value of the data register (used by stores) |
| mem_rdata | input | 32 | Word returned by memory one cycle after a read request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_be | output | 4 | Byte enables, bit 3 = address offset 0 |
| mem_wdata | output | 32 | Lane-aligned store data |
| misalign | output | 1 | One-cycle flag for a suppressed misaligned access |
| ld_valid | output | 1 | Load result valid |
| ld_rd | output | 5 | Destination register index of the load result |
| ld_data | output | 32 | Extended load result |

## Verification
Errors in the decode or lane logic show up at the memory port in the cycle after the request, as a wrong enable pattern or a wrong replicated data lane. Errors in the captured offset or extension kind only show up two cycles after the request, as a wrong `ld_data`. They can go unseen unless the byte under test has its top bit set, so the memory holds words that mix positive and negative bytes. Errors in the pipeline valid bits show up as a missing or extra `ld_valid`, or as a `mem_req` that appears in spite of `misalign`. Because stores are read back by later loads of every offset, a wrong enable shows up again later as corrupted neighbouring bytes.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_t;

  typedef struct packed {
    logic      is_mem;
    logic      is_store;
    logic      sign_ext;
    acc_size_t size;
  } acc_kind_t;

  // 6-bit primary opcode values of the memory instructions
  localparam logic [5:0] OPC_LD_BYTE_S = 6'd4;
  localparam logic [5:0] OPC_LD_BYTE_U = 6'd16;
  localparam logic [5:0] OPC_LD_HALF_S = 6'd7;
  localparam logic [5:0] OPC_LD_HALF_U = 6'd11;
  localparam logic [5:0] OPC_LD_WORD   = 6'd10;
  localparam logic [5:0] OPC_ST_BYTE   = 6'd12;
  localparam logic [5:0] OPC_ST_HALF   = 6'd3;
  localparam logic [5:0] OPC_ST_WORD   = 6'd22;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
#(
  parameter int OPC_W = 6
) (
  input  logic [OPC_W-1:0] opc,
  output acc_kind_t        kind
);

  always_comb begin
    kind = '{is_mem: 1'b0, is_store: 1'b0, sign_ext: 1'b0, size: SZ_WORD};
    case (opc)
      OPC_LD_BYTE_S: kind = '{1'b1, 1'b0, 1'b1, SZ_BYTE};
      OPC_LD_BYTE_U: kind = '{1'b1, 1'b0, 1'b0, SZ_BYTE};
      OPC_LD_HALF_S: kind = '{1'b1, 1'b0, 1'b1, SZ_HALF};
      OPC_LD_HALF_U: kind = '{1'b1, 1'b0, 1'b0, SZ_HALF};
      OPC_LD_WORD:   kind = '{1'b1, 1'b0, 1'b0, SZ_WORD};
      OPC_ST_BYTE:   kind = '{1'b1, 1'b1, 1'b0, SZ_BYTE};
      OPC_ST_HALF:   kind = '{1'b1, 1'b1, 1'b0, SZ_HALF};
      OPC_ST_WORD:   kind = '{1'b1, 1'b1, 1'b0, SZ_WORD};
      default:       ;
    endcase
  end

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  acc_size_t         size,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] data,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata
);

  logic [LANES-1:0] be_byte;
  logic [LANES-1:0] be_half;

  // Lane k holds bits 8k+7:8k; big-endian offset of that lane is LANES-1-k
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int POS = LANES - 1 - k;
    assign be_byte[k] = (off == OFF_W'(POS));
    assign be_half[k] = (off[OFF_W-1:1] == (OFF_W-1)'(POS / 2));
  end

  always_comb begin
    case (size)
      SZ_BYTE: begin
        be    = be_byte;
        wdata = {LANES{data[7:0]}};
      end
      SZ_HALF: begin
        be    = be_half;
        wdata = {(LANES/2){data[15:0]}};
      end
      default: begin
        be    = '1;
        wdata = data;
      end
    endcase
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  acc_size_t         size,
  input  logic              sign_ext,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] result
);

  logic [7:0]  lane_b [LANES];
  logic [15:0] lane_h [LANES/2];

  for (genvar k = 0; k < LANES; k++) begin : g_b
    assign lane_b[k] = word[8*k +: 8];
  end
  for (genvar j = 0; j < LANES/2; j++) begin : g_h
    assign lane_h[j] = word[16*j +: 16];
  end

  logic [OFF_W-1:0] b_idx;
  logic [OFF_W-2:0] h_idx;
  logic [7:0]       b_sel;
  logic [15:0]      h_sel;

  assign b_idx = OFF_W'(LANES - 1) - off;
  assign h_idx = (OFF_W-1)'(LANES/2 - 1) - off[OFF_W-1:1];
  assign b_sel = lane_b[b_idx];
  assign h_sel = lane_h[h_idx];

  always_comb begin
    case (size)
      SZ_BYTE: result = {{(DATA_W-8){sign_ext & b_sel[7]}}, b_sel};
      SZ_HALF: result = {{(DATA_W-16){sign_ext & h_sel[15]}}, h_sel};
      default: result = word;
    endcase
  end

endmodule

// File: rtl/be_lsu_align.sv
module be_lsu_align
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int REG_W  = 5,
  parameter int OPC_W  = 6,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int OPC_LSB = DATA_W - OPC_W,
  localparam int RD_LSB  = IMM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] base_val,
  input  logic [DATA_W-1:0] data_val,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              misalign,
  output logic              ld_valid,
  output logic [REG_W-1:0]  ld_rd,
  output logic [DATA_W-1:0] ld_data
);

  // ---------------- issue stage (combinational) ----------------
  acc_kind_t         kind;
  logic [IMM_W-1:0]  disp;
  logic [ADDR_W-1:0] ea;
  logic [OFF_W-1:0]  off;
  logic              bad_align;
  logic              go;
  logic [LANES-1:0]  be_n;
  logic [DATA_W-1:0] wdata_n;

  lsu_decode #(.OPC_W(OPC_W)) u_dec (
    .opc  (instr[OPC_LSB +: OPC_W]),
    .kind (kind)
  );

  assign disp = instr[IMM_W-1:0];
  assign ea   = base_val[ADDR_W-1:0] + {{(ADDR_W-IMM_W){disp[IMM_W-1]}}, disp};
  assign off  = ea[OFF_W-1:0];

  always_comb begin
    case (kind.size)
      SZ_HALF: bad_align = off[0];
      SZ_WORD: bad_align = |off;
      default: bad_align = 1'b0;
    endcase
  end

  assign go = req_valid & kind.is_mem & ~bad_align;

  lsu_store_lanes #(.DATA_W(DATA_W)) u_st (
    .size  (kind.size),
    .off   (off),
    .data  (data_val),
    .be    (be_n),
    .wdata (wdata_n)
  );

  // ---------------- request stage (registered) ----------------
  logic             s1_load, s2_load;
  logic [REG_W-1:0] s1_rd, s2_rd;
  acc_size_t        s1_size, s2_size;
  logic             s1_sext, s2_sext;
  logic [OFF_W-1:0] s1_off, s2_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      misalign  <= 1'b0;
      s1_load   <= 1'b0;
      s1_rd     <= '0;
      s1_size   <= SZ_WORD;
      s1_sext   <= 1'b0;
      s1_off    <= '0;
    end else begin
      mem_req   <= go;
      mem_we    <= go & kind.is_store;
      mem_addr  <= ea;
      mem_be    <= go ? be_n : '0;
      mem_wdata <= wdata_n;
      misalign  <= req_valid & kind.is_mem & bad_align;
      s1_load   <= go & ~kind.is_store;
      s1_rd     <= instr[RD_LSB +: REG_W];
      s1_size   <= kind.size;
      s1_sext   <= kind.sign_ext;
      s1_off    <= off;
    end
  end

  // ---------------- data-return stage ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_load <= 1'b0;
      s2_rd   <= '0;
      s2_size <= SZ_WORD;
      s2_sext <= 1'b0;
      s2_off  <= '0;
    end else begin
      s2_load <= s1_load;
      s2_rd   <= s1_rd;
      s2_size <= s1_size;
      s2_sext <= s1_sext;
      s2_off  <= s1_off;
    end
  end

  logic [DATA_W-1:0] ext_n;

  lsu_load_extract #(.DATA_W(DATA_W)) u_ld (
    .size     (s2_size),
    .sign_ext (s2_sext),
    .off      (s2_off),
    .word     (mem_rdata),
    .result   (ext_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      ld_rd    <= '0;
      ld_data  <= '0;
    end else begin
      ld_valid <= s2_load;
      ld_rd    <= s2_rd;
      ld_data  <= ext_n;
    end
  end

  // ---------------- assertions ----------------
  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> (!mem_req && !ld_valid && !misalign)); // R1
  AST_REQ_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (rst) mem_req |-> $past(req_valid)); // R2
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_be == 4'b1000 || mem_be == 4'b0100 || mem_be == 4'b0010 || mem_be == 4'b0001 ||
                 mem_be == 4'b1100 || mem_be == 4'b0011 || mem_be == 4'b1111)); // R3
  AST_HALF_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $countones(mem_be) == 2) |-> !mem_addr[0]); // R4
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_be == 4'b1111) |-> (mem_addr[1:0] == 2'b00)); // R5
  AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(mem_req && !mem_we, 2)); // R9
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> !ld_valid || $past(mem_req && !mem_we, 1)); // R9
  AST_MISALIGN_BLOCKS: assert property (@(posedge clk) disable iff (rst) misalign |-> !mem_req); // R10
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (!req_valid) |=> (!mem_req && !misalign)); // R11

endmodule

// File: tb/tb_be_lsu_align.sv
module tb_be_lsu_align;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] instr = '0, base_val = '0, data_val = '0;
  logic [31:0] mem_rdata = '0;
  logic        mem_req, mem_we, misalign, ld_valid;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [3:0]  mem_be;
  logic [4:0]  ld_rd;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  be_lsu_align dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .instr(instr),
    .base_val(base_val), .data_val(data_val), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .misalign(misalign), .ld_valid(ld_valid),
    .ld_rd(ld_rd), .ld_data(ld_data)
  );

  // 16-word memory model driven by the design, plus a bench shadow copy
  logic [31:0] mem    [16];
  logic [31:0] shadow [16];

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) mem[mem_addr[5:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[5:2]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  localparam logic [5:0] O_LB = 6'd4, O_LBU = 6'd16, O_LH = 6'd7, O_LHU = 6'd11, O_LW = 6'd10;
  localparam logic [5:0] O_SB = 6'd12, O_SH = 6'd3, O_SW = 6'd22;

  task automatic do_op(input bit vld, input logic [5:0] opc, input logic [31:0] base,
                       input logic [15:0] imm, input logic [4:0] rd, input logic [31:0] dat);
    logic [31:0] ea, exp_be32, exp_wd, word, exp_ld, field;
    logic [1:0]  off;
    bit is_ld, is_st, sz_b, sz_h, sz_w, sgn, bad, go;
    ea    = base + {{16{imm[15]}}, imm};
    off   = ea[1:0];
    is_ld = (opc == O_LB) || (opc == O_LBU) || (opc == O_LH) || (opc == O_LHU) || (opc == O_LW);
    is_st = (opc == O_SB) || (opc == O_SH) || (opc == O_SW);
    sz_b  = (opc == O_LB) || (opc == O_LBU) || (opc == O_SB);
    sz_h  = (opc == O_LH) || (opc == O_LHU) || (opc == O_SH);
    sz_w  = (opc == O_LW) || (opc == O_SW);
    sgn   = (opc == O_LB) || (opc == O_LH);
    bad   = (sz_h && off[0]) || (sz_w && off != 2'd0);
    go    = vld && (is_ld || is_st) && !bad;

    @(negedge clk);
    req_valid = vld;
    instr     = {opc, 5'd3, rd, imm};
    base_val  = base;
    data_val  = dat;
    @(negedge clk);
    req_valid = 1'b0;

    chk(mem_req == go, go ? "R2" : (bad ? "R10" : "R11"), "mem_req", 32'(mem_req), 32'(go));
    chk(misalign == (vld && (is_ld || is_st) && bad), "R10", "misalign",
        32'(misalign), 32'(vld && (is_ld || is_st) && bad));
    if (go) begin
      chk(mem_addr == ea, "R2", "mem_addr", mem_addr, ea);
      chk(mem_we == is_st, "R5", "mem_we", 32'(mem_we), 32'(is_st));
      if (is_st) begin
        if (sz_b) begin
          exp_be32 = 32'(4'b1000 >> off);
          exp_wd   = {4{dat[7:0]}};
        end else if (sz_h) begin
          exp_be32 = off[1] ? 32'h3 : 32'hC;
          exp_wd   = {2{dat[15:0]}};
        end else begin
          exp_be32 = 32'hF;
          exp_wd   = dat;
        end
        chk(32'(mem_be) == exp_be32, sz_b ? "R3" : (sz_h ? "R4" : "R5"), "mem_be", 32'(mem_be), exp_be32);
        chk(mem_wdata == exp_wd, sz_b ? "R3" : (sz_h ? "R4" : "R5"), "mem_wdata", mem_wdata, exp_wd);
        for (int k = 0; k < 4; k++)
          if (exp_be32[k]) shadow[ea[5:2]][8*k +: 8] = exp_wd[8*k +: 8];
      end
    end

    @(negedge clk);
    chk(ld_valid == 1'b0, "R9", "ld_valid early", 32'(ld_valid), 0);

    @(negedge clk);
    chk(ld_valid == (go && is_ld), is_ld ? "R9" : "R11", "ld_valid", 32'(ld_valid), 32'(go && is_ld));
    if (go && is_ld) begin
      word = shadow[ea[5:2]];
      if (sz_b) begin
        field  = (word >> (8 * (3 - off))) & 32'hFF;
        exp_ld = (sgn && field >= 32'd128) ? field - 32'd256 : field;
      end else if (sz_h) begin
        field  = (word >> (16 * (1 - off[1]))) & 32'hFFFF;
        exp_ld = (sgn && field >= 32'd32768) ? field - 32'd65536 : field;
      end else begin
        exp_ld = word;
      end
      chk(ld_data == exp_ld, sz_b ? "R6" : (sz_h ? "R7" : "R8"), "ld_data", ld_data, exp_ld);
      chk(ld_rd == rd, "R9", "ld_rd", 32'(ld_rd), 32'(rd));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [5:0] st_ops [3];
    logic [5:0] ld_ops [5];
    st_ops = '{O_SB, O_SH, O_SW};
    ld_ops = '{O_LB, O_LBU, O_LH, O_LHU, O_LW};
    for (int i = 0; i < 16; i++) begin
      mem[i]    = 32'h8F1E_7A35 ^ (32'(i) * 32'h1357_9BDF);
      shadow[i] = mem[i];
    end
    repeat (4) @(negedge clk);
    chk(!mem_req && !ld_valid && !misalign && mem_be == 4'h0, "R1", "reset outputs",
        {28'(0), mem_req, ld_valid, misalign, |mem_be}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_req && !ld_valid && !misalign, "R1", "after reset",
        {29'(0), mem_req, ld_valid, misalign}, 0);

    // R2: initial loads, including negative displacement and wrap-around
    do_op(1'b1, O_LW, 32'hFFFF_FFF0, 16'h0014, 5'd7, 32'h0);
    do_op(1'b1, O_LW, 32'h0001_0040, 16'h8000 + 16'h7FC4, 5'd9, 32'h0);
    do_op(1'b1, O_LBU, 32'h0000_0100, 16'hFF05, 5'd2, 32'h0);

    // R3 R4 R5 R10: stores, every size at every offset
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < 4; o++) begin
        int w;
        w = (s * 4 + o) % 16;
        do_op(1'b1, st_ops[s], 32'h0000_0040, 16'(-64 + 4 * w + o), 5'd4,
              32'hC3A5_96E1 ^ (32'(w) * 32'h0103_0507));
      end

    // R6 R7 R8 R10: loads of every kind, every word, every offset
    for (int l = 0; l < 5; l++)
      for (int w = 0; w < 16; w++)
        for (int o = 0; o < 4; o++)
          do_op(1'b1, ld_ops[l], 32'h0000_0020, 16'(-32 + 4 * w + o), 5'(w + o + 1), 32'h0);

    // R11: foreign opcodes and a memory opcode without req_valid
    do_op(1'b1, 6'd45, 32'h0, 16'h0, 5'd1, 32'hFFFF_FFFF);
    do_op(1'b1, 6'd63, 32'h0, 16'h4, 5'd1, 32'hFFFF_FFFF);
    do_op(1'b0, O_SW, 32'h0, 16'h0, 5'd1, 32'hDEAD_BEEF);
    do_op(1'b0, O_LW, 32'h0, 16'h0, 5'd1, 32'h0);
    do_op(1'b1, O_LW, 32'h0, 16'h0, 5'd6, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule